// File: doc/BRIEF.md
# Cascaded Interrupt Cause Controller

This block collects 96 interrupt requests into three 32-bit groups and reduces them to a single CPU interrupt line plus a readable vector that names the request to service. The first two groups, "main low" and "main high", carry requests from on-chip units. The third group, "general-purpose port" (GPP), carries requests from general-purpose pins. Each group has a cause register and an enable mask. Both main groups pass through fixed validity filters before the search.

The GPP group is cascaded behind the main high group. Four summary bits in the main high cause (bits 24 to 27) each stand for one byte lane of the enabled GPP cause. When the search lands on one of those summary bits, it continues in the GPP cause and adds 64 to the result. Software uses the vector register in its interrupt handler:

1. Read the vector register.
2. Service the source it names.
3. For a GPP source, clear that one cause bit by writing a word whose only 0 is at that bit position.

GPP inputs are treated as level requests that set sticky cause bits. The main group inputs are sampled every clock.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the registers hold these values:
  - every cause register reads 0;
  - the low mask and the GPP mask read 0;
  - the high mask reads 0x0F000000;
  - the vector reads 0x0000007F;
  - `cpu_irq_o` is low.
- R2: The low cause (offset 0) shows `src_lo_i` one clock after it is sampled. The high cause (offset 1) shows `src_hi_i` one clock after it is sampled, except in bits 24–27. Both cause registers are read-only: bus writes to them are ignored.
- R3: A GPP cause bit (offset 2) is set at every clock edge where its `gpp_i` bit is high. It stays set until software clears it.
- R4: A write to the GPP cause clears each bit written as 0 and keeps each bit written as 1. If a bit's `gpp_i` is high in the same cycle, the set wins.
- R5: The three masks are read/write at these offsets: low mask at 3, high mask at 4, GPP mask at 5. A mask bit of 1 enables its source.
- R6: For the low group, only the bits set in 0x3DFFFFFE can be selected. A candidate must be set in the cause, in this filter and in the low mask.
- R7: For the high group, only the bits set in 0x0F000DB7 can be selected. A candidate must be set in the effective high cause, in this filter and in the high mask.
- R8: When any low candidate exists, the result comes from the low group. The high group is searched only when there is no low candidate.
- R9: Within a group, the highest-numbered candidate wins. A low bit i gives number i. A high bit i below 24 gives number 32+i.
- R10: High cause bit 24+k reads as the OR of GPP cause bits 8k..8k+7 ANDed with the GPP mask, for k = 0..3. When the high search selects such a bit, the result is 64 plus the highest enabled GPP cause bit.
- R11: The vector register (offset 6) reads as follows:
  - when a number is found: bit 31 = 1 and bits 6:0 = the number (0–95);
  - otherwise: the value 0x0000007F.
  
  All other bits read 0.
- R12: `cpu_irq_o` is high exactly when the vector register would report bit 31 = 1.
- R13: Offsets 7 to 15 read 0. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_lo_i | input | 32 | Main low group request levels |
| src_hi_i | input | 32 | Main high group request levels (bits 24–27 unused) |
| gpp_i | input | 32 | General-purpose port request levels |
| bus_addr_i | input | 4 | Register word offset |
| bus_we_i | input | 1 | Write strobe, taken at the clock edge |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| cpu_irq_o | output | 1 | Interrupt request to the CPU |

## Verification
The cause and mask registers are the only state. A wrong bit in any of them shows up on the vector read and on `cpu_irq_o` in the same cycle, provided the wrong bit is an enabled, filtered candidate. Otherwise it shows up on the read-back of the register itself. A lost GPP bit or a bit that fails to clear shows in the GPP cause read-back one clock after the edge that should have set or cleared it. It also shows through the summary lane in the high cause read and through a redirected vector. Priority faults only show when two or more candidates are pending at once. For this reason the stimulus keeps several candidates pending together in every group, including GPP summary bits competing with ordinary high bits.

// File: rtl/irq_cascade_pkg.sv
// Package: shared constants for the cascaded interrupt cause controller.
// Assumes 32-bit groups and a 4-bit word offset register bus.
package irq_cascade_pkg;
    localparam int GRP_W    = 32;
    localparam int NUM_W    = 7;
    localparam int LANE_W   = 8;
    localparam int SUM_BASE = 24;

    // Register word offsets
    localparam int OFF_LO_CAUSE  = 0;
    localparam int OFF_HI_CAUSE  = 1;
    localparam int OFF_GPP_CAUSE = 2;
    localparam int OFF_LO_MASK   = 3;
    localparam int OFF_HI_MASK   = 4;
    localparam int OFF_GPP_MASK  = 5;
    localparam int OFF_VECTOR    = 6;

    localparam logic [GRP_W-1:0] LO_VALID    = 32'h3DFF_FFFE;
    localparam logic [GRP_W-1:0] HI_VALID    = 32'h0F00_0DB7;
    localparam logic [GRP_W-1:0] HI_MASK_RST = 32'h0F00_0000;
    localparam logic [NUM_W-1:0] SPUR_CODE   = 7'h7F;
endpackage

// File: rtl/irq_prio_find.sv
// Module: highest-set-bit finder over a W-bit request vector.
// Assumes nothing about one-hotness; idx is 0 when found is low.
module irq_prio_find #(
    parameter int W = 32,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan upward so that the last (highest) set bit is kept
    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = 0; i < W; i++) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/irq_gpp_cause.sv
// Module: sticky GPP cause register with write-zero-to-clear and
// per-lane enabled summaries. Assumes W is a multiple of LANE_W.
module irq_gpp_cause #(
    parameter int W      = 32,
    parameter int LANE_W = 8,
    localparam int LANES = W / LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     req_i,
    input  logic             clr_we_i,
    input  logic [W-1:0]     keep_i,
    input  logic [W-1:0]     mask_i,
    output logic [W-1:0]     cause_o,
    output logic [LANES-1:0] lane_sum_o
);
    logic [W-1:0] cause_q;

    // Set from requests, clear bits written as zero; set dominates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= '0;
        end else begin
            cause_q <= (clr_we_i ? (cause_q & keep_i) : cause_q) | req_i;
        end
    end

    assign cause_o = cause_q;

    // One enabled-OR summary per byte lane
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_sum_o[k] = |(cause_q[k*LANE_W +: LANE_W] & mask_i[k*LANE_W +: LANE_W]);
    end
endmodule

// File: rtl/irq_cascade_sel.sv
// Module: two-level vector selection. Low group first, then high group;
// a high pick at or above SUM_BASE redirects into the GPP group (+64).
// Assumes all inputs are registered state; output is combinational.
module irq_cascade_sel #(
    parameter int               W        = 32,
    parameter int               NW       = 7,
    parameter int               SUM_BASE = 24,
    parameter logic [W-1:0]     LO_FILT  = 32'h3DFF_FFFE,
    parameter logic [W-1:0]     HI_FILT  = 32'h0F00_0DB7,
    parameter logic [NW-1:0]    SPUR     = 7'h7F,
    localparam int              IW       = $clog2(W)
) (
    input  logic [W-1:0]  lo_cause_i,
    input  logic [W-1:0]  lo_mask_i,
    input  logic [W-1:0]  hi_cause_i,
    input  logic [W-1:0]  hi_mask_i,
    input  logic [W-1:0]  gpp_cause_i,
    input  logic [W-1:0]  gpp_mask_i,
    output logic          valid_o,
    output logic [NW-1:0] num_o
);
    logic          lo_found, hi_found, gpp_found;
    logic [IW-1:0] lo_idx, hi_idx, gpp_idx;

    irq_prio_find #(.W(W)) i_find_lo (
        .req(lo_cause_i & LO_FILT & lo_mask_i), .found(lo_found), .idx(lo_idx));
    irq_prio_find #(.W(W)) i_find_hi (
        .req(hi_cause_i & HI_FILT & hi_mask_i), .found(hi_found), .idx(hi_idx));
    irq_prio_find #(.W(W)) i_find_gpp (
        .req(gpp_cause_i & gpp_mask_i), .found(gpp_found), .idx(gpp_idx));

    // Cascade priority: low group, then high group, then GPP via summary
    always_comb begin
        valid_o = 1'b0;
        num_o   = SPUR;
        if (lo_found) begin
            valid_o = 1'b1;
            num_o   = NW'(lo_idx);
        end else if (hi_found) begin
            if (int'(hi_idx) >= SUM_BASE) begin
                if (gpp_found) begin
                    valid_o = 1'b1;
                    num_o   = NW'(2 * W) + NW'(gpp_idx);
                end
            end else begin
                valid_o = 1'b1;
                num_o   = NW'(W) + NW'(hi_idx);
            end
        end
    end
endmodule

// File: rtl/irq_cascade_ctrl.sv
// Module: top of the cascaded interrupt cause controller. Holds the main
// cause and mask registers, decodes the single-cycle register bus and
// drives the CPU interrupt line. Assumes reads are combinational and
// writes take effect at the clock edge where bus_we_i is high.
module irq_cascade_ctrl
    import irq_cascade_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] src_lo_i,
    input  logic [DATA_W-1:0] src_hi_i,
    input  logic [DATA_W-1:0] gpp_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              cpu_irq_o
);
    localparam int LANES = DATA_W / LANE_W;
    localparam logic [DATA_W-1:0] SUM_FIELD = DATA_W'({LANES{1'b1}}) << SUM_BASE;
    localparam logic [ADDR_W-1:0] A_LO_CAUSE  = ADDR_W'(OFF_LO_CAUSE);
    localparam logic [ADDR_W-1:0] A_HI_CAUSE  = ADDR_W'(OFF_HI_CAUSE);
    localparam logic [ADDR_W-1:0] A_GPP_CAUSE = ADDR_W'(OFF_GPP_CAUSE);
    localparam logic [ADDR_W-1:0] A_LO_MASK   = ADDR_W'(OFF_LO_MASK);
    localparam logic [ADDR_W-1:0] A_HI_MASK   = ADDR_W'(OFF_HI_MASK);
    localparam logic [ADDR_W-1:0] A_GPP_MASK  = ADDR_W'(OFF_GPP_MASK);
    localparam logic [ADDR_W-1:0] A_VECTOR    = ADDR_W'(OFF_VECTOR);

    logic [DATA_W-1:0] lo_cause_q, hi_cause_q;
    logic [DATA_W-1:0] lo_mask_q, hi_mask_q, gpp_mask_q;
    logic [DATA_W-1:0] gpp_cause, hi_cause_eff;
    logic [LANES-1:0]  lane_sum;
    logic              vec_valid;
    logic [NUM_W-1:0]  vec_num;
    logic              wr_gpp_cause;

    // Sample the main group request levels; summary field stays zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_cause_q <= '0;
            hi_cause_q <= '0;
        end else begin
            lo_cause_q <= src_lo_i;
            hi_cause_q <= src_hi_i & ~SUM_FIELD;
        end
    end

    // Mask registers written from the bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_mask_q  <= '0;
            hi_mask_q  <= HI_MASK_RST;
            gpp_mask_q <= '0;
        end else if (bus_we_i) begin
            if (bus_addr_i == A_LO_MASK)  lo_mask_q  <= bus_wdata_i;
            if (bus_addr_i == A_HI_MASK)  hi_mask_q  <= bus_wdata_i;
            if (bus_addr_i == A_GPP_MASK) gpp_mask_q <= bus_wdata_i;
        end
    end

    assign wr_gpp_cause = bus_we_i && (bus_addr_i == A_GPP_CAUSE);

    irq_gpp_cause #(.W(DATA_W), .LANE_W(LANE_W)) i_gpp (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (gpp_i),
        .clr_we_i   (wr_gpp_cause),
        .keep_i     (bus_wdata_i),
        .mask_i     (gpp_mask_q),
        .cause_o    (gpp_cause),
        .lane_sum_o (lane_sum)
    );

    // Overlay the GPP lane summaries onto the high cause
    assign hi_cause_eff = hi_cause_q | (DATA_W'(lane_sum) << SUM_BASE);

    irq_cascade_sel #(
        .W        (DATA_W),
        .NW       (NUM_W),
        .SUM_BASE (SUM_BASE),
        .LO_FILT  (LO_VALID),
        .HI_FILT  (HI_VALID),
        .SPUR     (SPUR_CODE)
    ) i_sel (
        .lo_cause_i  (lo_cause_q),
        .lo_mask_i   (lo_mask_q),
        .hi_cause_i  (hi_cause_eff),
        .hi_mask_i   (hi_mask_q),
        .gpp_cause_i (gpp_cause),
        .gpp_mask_i  (gpp_mask_q),
        .valid_o     (vec_valid),
        .num_o       (vec_num)
    );

    assign cpu_irq_o = vec_valid;

    // Combinational read-data decode
    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            A_LO_CAUSE:  bus_rdata_o = lo_cause_q;
            A_HI_CAUSE:  bus_rdata_o = hi_cause_eff;
            A_GPP_CAUSE: bus_rdata_o = gpp_cause;
            A_LO_MASK:   bus_rdata_o = lo_mask_q;
            A_HI_MASK:   bus_rdata_o = hi_mask_q;
            A_GPP_MASK:  bus_rdata_o = gpp_mask_q;
            A_VECTOR: begin
                bus_rdata_o[DATA_W-1]  = vec_valid;
                bus_rdata_o[NUM_W-1:0] = vec_num;
            end
            default:     bus_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/irq_cascade_chk.sv
// Module: property checker for irq_cascade_ctrl, attached by bind.
// Assumes the default 32-bit data width and the package offsets.
module irq_cascade_chk
    import irq_cascade_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              cpu_irq,
    input logic [31:0]       gpp_in,
    input logic [31:0]       gpp_cause,
    input logic [31:0]       lo_cause,
    input logic [31:0]       lo_mask
);
    logic at_vec, wr_gpp;
    assign at_vec = (bus_addr == ADDR_W'(OFF_VECTOR));
    assign wr_gpp = bus_we && (bus_addr == ADDR_W'(OFF_GPP_CAUSE));

    AST_IRQ_MATCHES_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        at_vec |-> (bus_rdata[31] == cpu_irq)); // R12
    AST_SPURIOUS_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
        (at_vec && !bus_rdata[31]) |-> (bus_rdata == 32'h0000_007F)); // R11
    AST_NUMBER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (at_vec && bus_rdata[31]) |-> (bus_rdata[30:0] < 31'd96)); // R11
    AST_LOW_GROUP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (at_vec && ((lo_cause & lo_mask & LO_VALID) != 0)) |-> (bus_rdata[31] && bus_rdata[6:0] < 7'd32)); // R8
    AST_GPP_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_gpp |=> ((gpp_cause & ~$past(bus_wdata) & ~$past(gpp_in)) == 32'h0)); // R4
    AST_GPP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_gpp |=> ((gpp_cause & $past(gpp_cause)) == $past(gpp_cause))); // R3
    AST_GPP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((gpp_cause & $past(gpp_in)) == $past(gpp_in))); // R3
endmodule

bind irq_cascade_ctrl irq_cascade_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr_i),
    .bus_we    (bus_we_i),
    .bus_wdata (bus_wdata_i),
    .bus_rdata (bus_rdata_o),
    .cpu_irq   (cpu_irq_o),
    .gpp_in    (gpp_i),
    .gpp_cause (gpp_cause),
    .lo_cause  (lo_cause_q),
    .lo_mask   (lo_mask_q)
);

// File: tb/test_irq_cascade_ctrl.sv
// Bench: directed corner cases plus seeded random traffic, compared
// against a bench-side model of the requirements.
module test_irq_cascade_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_lo = '0, src_hi = '0, gpp_in = '0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cpu_irq;

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    // Bench model state
    logic [31:0] m_lo = '0, m_hi = '0, m_gpp = '0;
    logic [31:0] m_mlo = '0, m_mhi = 32'h0F00_0000, m_mgpp = '0;

    irq_cascade_ctrl i_irq_cascade_ctrl (
        .clk(clk), .rst_n(rst_n), .src_lo_i(src_lo), .src_hi_i(src_hi),
        .gpp_i(gpp_in), .bus_addr_i(bus_addr), .bus_we_i(bus_we),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .cpu_irq_o(cpu_irq));

    always #5 clk = ~clk;

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic int top_bit(input logic [31:0] x);
        for (int i = 31; i >= 0; i--) if (x[i]) return i;
        return -1;
    endfunction

    function automatic logic [31:0] exp_hi_eff();
        logic [31:0] r = m_hi;
        for (int k = 0; k < 4; k++)
            r[24+k] = |(m_gpp[8*k +: 8] & m_mgpp[8*k +: 8]);
        return r;
    endfunction

    function automatic logic [31:0] exp_vec();
        logic [31:0] lq, hq, gq;
        int t;
        lq = m_lo & 32'h3DFF_FFFE & m_mlo;
        if (lq != 0) return 32'h8000_0000 | 32'(top_bit(lq));
        hq = exp_hi_eff() & 32'h0F00_0DB7 & m_mhi;
        if (hq != 0) begin
            t = top_bit(hq);
            if (t >= 24) begin
                gq = m_gpp & m_mgpp;
                if (gq != 0) return 32'h8000_0000 | 32'(64 + top_bit(gq));
                return 32'h7F;
            end
            return 32'h8000_0000 | 32'(32 + t);
        end
        return 32'h7F;
    endfunction

    // Combinational read in the low clock phase
    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // One clock: drive bus from just after a negedge, update the model at
    // the posedge, return at the next negedge
    task automatic cycle(input logic wr, input logic [3:0] a, input logic [31:0] d);
        bus_we = wr; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        m_lo = src_lo;
        m_hi = src_hi & ~32'h0F00_0000;
        m_gpp = ((wr && a == 4'd2) ? (m_gpp & d) : m_gpp) | gpp_in;
        if (wr && a == 4'd3) m_mlo = d;
        if (wr && a == 4'd4) m_mhi = d;
        if (wr && a == 4'd5) m_mgpp = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic check_model(input string req);
        logic [31:0] d;
        rd(4'd6, d);
        chk(req, d, exp_vec());
        chk({req, " irq"}, {31'b0, cpu_irq}, {31'b0, exp_vec()[31]});
        rd(4'd2, d);
        chk({req, " gpp cause"}, d, m_gpp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run did not complete actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values of every register and the interrupt line
        rd(4'd0, d); chk("R1 lo cause", d, 32'h0);
        rd(4'd1, d); chk("R1 hi cause", d, 32'h0);
        rd(4'd2, d); chk("R1 gpp cause", d, 32'h0);
        rd(4'd3, d); chk("R1 lo mask", d, 32'h0);
        cycle(1'b0, 4'd0, 32'h0);
        rd(4'd4, d); chk("R1 hi mask", d, 32'h0F00_0000);
        rd(4'd5, d); chk("R1 gpp mask", d, 32'h0);
        rd(4'd6, d); chk("R1 vector", d, 32'h0000_007F);
        chk("R1 irq", {31'b0, cpu_irq}, 32'h0);

        // R13: unused offsets read zero and ignore writes
        cycle(1'b1, 4'd9, 32'hFFFF_FFFF);
        rd(4'd9, d); chk("R13 unused offset", d, 32'h0);
        rd(4'd15, d); chk("R13 top offset", d, 32'h0);

        // R5: mask read/write
        cycle(1'b1, 4'd3, 32'hFFFF_FFFF);
        rd(4'd3, d); chk("R5 lo mask write", d, 32'hFFFF_FFFF);

        // R2: cause captured one clock later; writes to it ignored
        src_lo = 32'hFFFF_FFFF;
        rd(4'd0, d); chk("R2 lo cause before edge", d, 32'h0);
        cycle(1'b1, 4'd0, 32'h0);
        rd(4'd0, d); chk("R2 lo cause capture, write ignored", d, 32'hFFFF_FFFF);
        // R6 R9: filter drops bits 31,30,25,0; highest candidate is 29
        rd(4'd6, d); chk("R6 R9 low filtered pick", d, 32'h8000_001D);

        // R6: bit 0 alone is filtered out -> spurious
        src_lo = 32'h0000_0001;
        cycle(1'b0, 4'd0, 32'h0);
        rd(4'd6, d); chk("R6 low bit0 filtered", d, 32'h0000_007F);
        chk("R12 irq low when spurious", {31'b0, cpu_irq}, 32'h0);

        // R7 R9: high group, filter 0x0F000DB7 -> highest normal bit 11 -> 43
        src_hi = 32'hFFFF_FFFF;
        cycle(1'b1, 4'd4, 32'hFFFF_FFFF);
        rd(4'd1, d); chk("R2 hi cause summary field", d, 32'hF0FF_FFFF);
        rd(4'd6, d); chk("R7 R9 high pick", d, 32'h8000_002B);
        chk("R12 irq high", {31'b0, cpu_irq}, 32'h1);

        // R8: a low candidate wins over high
        src_lo = 32'h0000_0002;
        cycle(1'b0, 4'd0, 32'h0);
        rd(4'd6, d); chk("R8 low first", d, 32'h8000_0001);
        src_lo = 32'h0;

        // R10: GPP bit 9 enabled -> summary bit 25 beats bit 11 -> 73
        gpp_in = 32'h0000_0200;
        cycle(1'b1, 4'd5, 32'h0000_0200);
        gpp_in = 32'h0;
        rd(4'd6, d); chk("R10 cascade to gpp", d, 32'h8000_0049);
        rd(4'd1, d); chk("R10 summary lane 1", d, 32'hF2FF_FFFF);

        // R3: sticky after input drops
        cycle(1'b0, 4'd0, 32'h0);
        rd(4'd2, d); chk("R3 gpp sticky", d, 32'h0000_0200);
        // R4: writing all ones keeps, writing a single zero clears
        cycle(1'b1, 4'd2, 32'hFFFF_FFFF);
        rd(4'd2, d); chk("R4 write ones keeps", d, 32'h0000_0200);
        cycle(1'b1, 4'd2, 32'hFFFF_FDFF);
        rd(4'd2, d); chk("R4 write zero clears", d, 32'h0);
        rd(4'd6, d); chk("R4 back to high pick", d, 32'h8000_002B);

        // R4: set wins over clear; R10: unmasked GPP bit gives no summary
        src_hi = 32'h0;
        gpp_in = 32'h0000_0008;
        cycle(1'b1, 4'd2, 32'h0);
        gpp_in = 32'h0;
        rd(4'd2, d); chk("R4 set wins", d, 32'h0000_0008);
        rd(4'd6, d); chk("R10 masked gpp no summary", d, 32'h0000_007F);
        cycle(1'b1, 4'd2, 32'h0);

        // Random traffic checked against the model
        for (int it = 0; it < 600; it++) begin
            logic [31:0] wd;
            int act;
            src_lo = ($urandom_range(0, 1) == 0) ? 32'h0 : ($urandom & $urandom);
            src_hi = ($urandom & $urandom);
            gpp_in = ($urandom_range(0, 3) == 0) ? (32'h1 << $urandom_range(0, 31)) : 32'h0;
            act = $urandom_range(0, 7);
            wd  = $urandom;
            case (act)
                0: cycle(1'b1, 4'd3, wd & $urandom);
                1: cycle(1'b1, 4'd4, wd);
                2: cycle(1'b1, 4'd5, wd);
                3: cycle(1'b1, 4'd2, ~(32'h1 << $urandom_range(0, 31)));
                4: cycle(1'b1, 4'd2, wd);
                5: cycle(1'b1, 4'd0, wd);
                default: cycle(1'b0, 4'd0, 32'h0);
            endcase
            check_model("R3 R4 R9 R10 R12 random");
        end
        finish_run();
    end
endmodule